// File: doc/BRIEF.md
# Banked Store Write Queue

This block buffers the data of retired store instructions before it reaches a banked data cache. Each cache bank has its own first-in first-out queue. A retiring store names its bank, its address and one doubleword of data, and it joins the tail of that bank's queue. A queue sends its oldest entry to the cache only on a cycle when its bank's port would otherwise be wasted. That is a cycle when the bank is idle, or a cycle when the bank is doing a tag lookup for another store. A bank that is serving a load is never given a queued write, so queued stores never compete with loads for the cache.

Each bank raises a full flag so that retirement can hold back a store aimed at that bank. Loads can probe the queue with a bank and an address. A probe reports whether that bank still holds a store to the same address, and it returns the data of the newest such store, so the load does not pick up stale cache contents.

Top module: `store_write_queue`

## Requirements
- R1: A store is taken into the queue of the bank named by `st_bank` on a rising edge where `st_valid` is high and that bank's `bank_full` is low. A bank never issues a write command unless it holds an entry that was taken in this way.
- R2: Each bank queue holds DEPTH entries (11 by default). `bank_full[b]` is high exactly while bank b holds DEPTH entries. It is updated at the same edge that changes the entry count.
- R3: A store offered to a bank whose `bank_full` is high is discarded. It is never written and never matched by a load probe.
- R4: When `bank_idle[b]` is high at a rising edge and bank b holds an entry, its oldest entry is removed. From that edge on, `wr_valid[b]` is high for one cycle with the entry's address on `wr_addr[b*ADDR_W +: ADDR_W]` and its data on `wr_data[b*DATA_W +: DATA_W]`.
- R5: The same drain as in R4 happens at an edge where `bank_tag_busy[b]` is high, even when `bank_idle[b]` is low.
- R6: At an edge where both `bank_idle[b]` and `bank_tag_busy[b]` are low, meaning the bank is serving a load, bank b does not drain, and `wr_valid[b]` is low in the following cycle.
- R7: The entries of one bank are written out in the order in which they were accepted.
- R8: A bank's queue is affected only by stores that name that bank. Write commands, full flags and probe results of one bank are independent of the traffic to the others.
- R9: At a rising edge with `ld_valid` high, `ld_hit` is set to 1 if bank `ld_bank` held an entry with address `ld_addr` before that edge, and to 0 otherwise. An entry that is being drained at that same edge counts as held. A store accepted at that same edge does not count. On a hit, `ld_data` takes the data of the newest matching entry. On a miss, or when `ld_valid` is low, `ld_hit` is 0 and `ld_data` is 0.
- R10: While `rst` is high at a rising edge, every queue is emptied, and `wr_valid`, `bank_full`, `ld_hit` and `ld_data` are all cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | A retiring store is presented |
| st_bank | input | BANK_W | Bank targeted by the store |
| st_addr | input | ADDR_W | Store address |
| st_data | input | DATA_W | Store doubleword |
| bank_idle | input | NUM_BANKS | Per bank: the cache port is unused this cycle |
| bank_tag_busy | input | NUM_BANKS | Per bank: the port is doing another store's tag lookup |
| ld_valid | input | 1 | A load probe is presented |
| ld_bank | input | BANK_W | Bank probed by the load |
| ld_addr | input | ADDR_W | Load address compared with queued stores |
| wr_valid | output | NUM_BANKS | Per bank: a cache write command is issued |
| wr_addr | output | NUM_BANKS*ADDR_W | Per bank write address, bank b in slice b |
| wr_data | output | NUM_BANKS*DATA_W | Per bank write data, bank b in slice b |
| bank_full | output | NUM_BANKS | Per bank: the queue is full, so retirement must stall |
| ld_hit | output | 1 | The probed bank holds a store to the load address |
| ld_data | output | DATA_W | Data of the newest matching queued store |

## Verification
Two situations can fall into the same cycle and need care. In the first, a bank accepts a retiring store at the same edge at which it drains its head toward the cache. In the second, a load probes an address whose only queued copy is the head that is being drained at that same edge. The bench produces both by driving stores, drain permissions and probes at random on a narrow range of addresses, and by adding directed sequences that fill a bank and then drain it. A bench-side queue model gives the expected result. The count used for full and accept decisions is the count before the edge. A probe sees the entries held before the edge, including a head that is leaving, and it does not see a store that is arriving at that edge.

// File: rtl/swq_pkg.sv
package swq_pkg;

  // Advance a ring pointer by one slot, wrapping at depth.
  function automatic int unsigned ring_next(input int unsigned ptr, input int unsigned depth);
    return (ptr + 1 >= depth) ? 0 : ptr + 1;
  endfunction

endpackage

// File: rtl/swq_search.sv
module swq_search #(
  parameter int DEPTH  = 11,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [ADDR_W-1:0] slot_addr [DEPTH],
  input  logic [DATA_W-1:0] slot_data [DEPTH],
  input  logic [PTR_W-1:0]  head,
  input  logic [CNT_W-1:0]  count,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic              hit,
  output logic [DATA_W-1:0] hit_data
);

  // Walk the slots from oldest to newest; a later match overrides an
  // earlier one, so the newest matching store supplies the data.
  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      int pos;
      pos = int'(head) + i;
      if (pos >= DEPTH) pos = pos - DEPTH;
      if ((i < int'(count)) && (slot_addr[pos[PTR_W-1:0]] == probe_addr)) begin
        hit      = 1'b1;
        hit_data = slot_data[pos[PTR_W-1:0]];
      end
    end
  end

endmodule

// File: rtl/swq_bank.sv
module swq_bank
  import swq_pkg::*;
#(
  parameter int DEPTH  = 11,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  input  logic              drain_ok,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic              full,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              probe_hit,
  output logic [DATA_W-1:0] probe_data
);

  logic [ADDR_W-1:0] slot_addr [DEPTH];
  logic [DATA_W-1:0] slot_data [DEPTH];
  logic [PTR_W-1:0]  head, tail;
  logic [CNT_W-1:0]  count, count_nxt;
  logic              take, leave;

  assign take  = push && !full;
  assign leave = drain_ok && (count != '0);

  always_comb begin
    count_nxt = count;
    if (take && !leave)      count_nxt = count + 1'b1;
    else if (!take && leave) count_nxt = count - 1'b1;
  end

  // Entry storage: write port at the tail, no reset.
  always_ff @(posedge clk) begin
    if (take) begin
      slot_addr[tail] <= push_addr;
      slot_data[tail] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
      full  <= 1'b0;
    end else begin
      if (take)  tail <= PTR_W'(ring_next(int'(tail), DEPTH));
      if (leave) head <= PTR_W'(ring_next(int'(head), DEPTH));
      count <= count_nxt;
      full  <= (count_nxt == CNT_W'(DEPTH));
    end
  end

  // Registered cache write command.
  always_ff @(posedge clk) begin
    if (rst) wr_valid <= 1'b0;
    else     wr_valid <= leave;
  end

  always_ff @(posedge clk) begin
    if (leave) begin
      wr_addr <= slot_addr[head];
      wr_data <= slot_data[head];
    end
  end

  swq_search #(
    .DEPTH (DEPTH),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_search (
    .slot_addr (slot_addr),
    .slot_data (slot_data),
    .head      (head),
    .count     (count),
    .probe_addr(probe_addr),
    .hit       (probe_hit),
    .hit_data  (probe_data)
  );

  // R1: the entry count can only rise after a store was offered
  a_r1_grow_needs_push: assert property (@(posedge clk) disable iff (rst)
    !push |=> (count <= $past(count)));

  // R3: a full bank that cannot drain keeps its count when a store is offered
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (full && push && !drain_ok) |=> $stable(count));

  // R4: a write command follows only an edge where draining was permitted
  a_r4_drain_gate: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> $past(drain_ok));

  // R1: an empty bank issues no write in the next cycle
  a_r1_empty_quiet: assert property (@(posedge clk) disable iff (rst)
    (count == '0) |=> !wr_valid);

endmodule

// File: rtl/store_write_queue.sv
module store_write_queue #(
  parameter int NUM_BANKS = 2,
  parameter int DEPTH     = 11,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 64,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        st_valid,
  input  logic [BANK_W-1:0]           st_bank,
  input  logic [ADDR_W-1:0]           st_addr,
  input  logic [DATA_W-1:0]           st_data,
  input  logic [NUM_BANKS-1:0]        bank_idle,
  input  logic [NUM_BANKS-1:0]        bank_tag_busy,
  input  logic                        ld_valid,
  input  logic [BANK_W-1:0]           ld_bank,
  input  logic [ADDR_W-1:0]           ld_addr,
  output logic [NUM_BANKS-1:0]        wr_valid,
  output logic [NUM_BANKS*ADDR_W-1:0] wr_addr,
  output logic [NUM_BANKS*DATA_W-1:0] wr_data,
  output logic [NUM_BANKS-1:0]        bank_full,
  output logic                        ld_hit,
  output logic [DATA_W-1:0]           ld_data
);

  logic [NUM_BANKS-1:0] probe_hit;
  logic [DATA_W-1:0]    probe_data [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic push_b;
    logic drain_b;

    assign push_b  = st_valid && (st_bank == BANK_W'(b));
    assign drain_b = bank_idle[b] || bank_tag_busy[b];

    swq_bank #(
      .DEPTH (DEPTH),
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
    ) u_bank (
      .clk       (clk),
      .rst       (rst),
      .push      (push_b),
      .push_addr (st_addr),
      .push_data (st_data),
      .drain_ok  (drain_b),
      .probe_addr(ld_addr),
      .full      (bank_full[b]),
      .wr_valid  (wr_valid[b]),
      .wr_addr   (wr_addr[b*ADDR_W +: ADDR_W]),
      .wr_data   (wr_data[b*DATA_W +: DATA_W]),
      .probe_hit (probe_hit[b]),
      .probe_data(probe_data[b])
    );

    // R6: a bank serving a load gets no write in the next cycle
    a_r6_no_write_on_load: assert property (@(posedge clk) disable iff (rst)
      (!bank_idle[b] && !bank_tag_busy[b]) |=> !wr_valid[b]);
  end

  // Registered load probe result.
  always_ff @(posedge clk) begin
    if (rst) begin
      ld_hit  <= 1'b0;
      ld_data <= '0;
    end else if (ld_valid && probe_hit[ld_bank]) begin
      ld_hit  <= 1'b1;
      ld_data <= probe_data[ld_bank];
    end else begin
      ld_hit  <= 1'b0;
      ld_data <= '0;
    end
  end

  // R9: a hit is reported only after a probe was presented
  a_r9_hit_needs_probe: assert property (@(posedge clk) disable iff (rst)
    ld_hit |-> $past(ld_valid));

endmodule

// File: tb/tb_store_write_queue.sv
module tb_store_write_queue;
  localparam int NB     = 2;
  localparam int DEPTH  = 11;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 64;
  localparam int BANK_W = 1;

  logic clk = 1'b0;
  logic rst;
  logic st_valid;
  logic [BANK_W-1:0] st_bank;
  logic [ADDR_W-1:0] st_addr;
  logic [DATA_W-1:0] st_data;
  logic [NB-1:0] bank_idle, bank_tag_busy;
  logic ld_valid;
  logic [BANK_W-1:0] ld_bank;
  logic [ADDR_W-1:0] ld_addr;
  logic [NB-1:0] wr_valid;
  logic [NB*ADDR_W-1:0] wr_addr;
  logic [NB*DATA_W-1:0] wr_data;
  logic [NB-1:0] bank_full;
  logic ld_hit;
  logic [DATA_W-1:0] ld_data;

  always #10 clk = ~clk;

  store_write_queue #(.NUM_BANKS(NB), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_bank(st_bank), .st_addr(st_addr),
    .st_data(st_data), .bank_idle(bank_idle), .bank_tag_busy(bank_tag_busy),
    .ld_valid(ld_valid), .ld_bank(ld_bank), .ld_addr(ld_addr), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .bank_full(bank_full), .ld_hit(ld_hit),
    .ld_data(ld_data));

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Bench-side queue model, index 0 is the oldest entry.
  int                mq_cnt [NB];
  logic [ADDR_W-1:0] mq_a   [NB][DEPTH];
  logic [DATA_W-1:0] mq_d   [NB][DEPTH];

  logic              exp_wv   [NB];
  logic [ADDR_W-1:0] exp_wa   [NB];
  logic [DATA_W-1:0] exp_wd   [NB];
  string             exp_tag  [NB];
  logic              exp_full [NB];
  logic              exp_hit;
  logic [DATA_W-1:0] exp_hd;

  task automatic check(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DATA_W:0] model_lookup(input int b, input logic [ADDR_W-1:0] a);
    logic [DATA_W:0] r = '0;
    for (int i = 0; i < mq_cnt[b]; i++)
      if (mq_a[b][i] == a) r = {1'b1, mq_d[b][i]};
    return r;
  endfunction

  task automatic model_clear();
    for (int b = 0; b < NB; b++) mq_cnt[b] = 0;
  endtask

  // One clock: predict from the inputs now driven, advance, compare at negedge.
  task automatic step();
    logic [DATA_W:0] lk;
    int sb;
    bit accept;
    lk = model_lookup(int'(ld_bank), ld_addr);
    exp_hit = ld_valid && lk[DATA_W];
    exp_hd  = exp_hit ? lk[DATA_W-1:0] : '0;
    sb = int'(st_bank);
    accept = st_valid && (mq_cnt[sb] < DEPTH);
    for (int b = 0; b < NB; b++) begin
      exp_wv[b]  = (bank_idle[b] || bank_tag_busy[b]) && (mq_cnt[b] > 0);
      exp_tag[b] = (mq_cnt[b] == 0) ? "R1" : bank_idle[b] ? "R4" : bank_tag_busy[b] ? "R5" : "R6";
      if (exp_wv[b]) begin
        exp_wa[b] = mq_a[b][0];
        exp_wd[b] = mq_d[b][0];
        for (int i = 0; i < DEPTH - 1; i++) begin
          mq_a[b][i] = mq_a[b][i+1];
          mq_d[b][i] = mq_d[b][i+1];
        end
        mq_cnt[b]--;
      end
    end
    if (accept) begin
      mq_a[sb][mq_cnt[sb]] = st_addr;
      mq_d[sb][mq_cnt[sb]] = st_data;
      mq_cnt[sb]++;
    end
    for (int b = 0; b < NB; b++) exp_full[b] = (mq_cnt[b] == DEPTH);
    @(posedge clk);
    @(negedge clk);
    for (int b = 0; b < NB; b++) begin
      check(exp_tag[b], DATA_W'(wr_valid[b]), DATA_W'(exp_wv[b]));
      if (exp_wv[b] && wr_valid[b]) begin
        check("R7 addr", DATA_W'(wr_addr[b*ADDR_W +: ADDR_W]), DATA_W'(exp_wa[b]));
        check("R7 data", wr_data[b*DATA_W +: DATA_W], exp_wd[b]);
      end
      check("R2 full", DATA_W'(bank_full[b]), DATA_W'(exp_full[b]));
    end
    check("R9 hit", DATA_W'(ld_hit), DATA_W'(exp_hit));
    check("R9 data", ld_data, exp_hd);
  endtask

  task automatic quiet();
    st_valid = 0; st_bank = '0; st_addr = '0; st_data = '0;
    bank_idle = '0; bank_tag_busy = '0;
    ld_valid = 0; ld_bank = '0; ld_addr = '0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    quiet();
    model_clear();
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R10: reset state
    check("R10 wr_valid", DATA_W'(wr_valid), '0);
    check("R10 full", DATA_W'(bank_full), '0);
    check("R10 ld_hit", DATA_W'(ld_hit), '0);
    check("R10 ld_data", ld_data, '0);

    // Fill bank 0 while it serves loads (R6), then offer one store too many (R3).
    for (int i = 0; i < DEPTH + 1; i++) begin
      st_valid = 1; st_bank = 0;
      st_addr = (i == DEPTH) ? 16'h0200 : 16'h0100 + 16'(i);
      st_data = {32'hA5A5_0000, 32'(i)};
      step();
    end
    quiet();
    check("R2 full after fill", DATA_W'(bank_full[0]), 64'd1);
    check("R8 other bank not full", DATA_W'(bank_full[1]), 64'd0);
    ld_valid = 1; ld_bank = 0; ld_addr = 16'h0200;
    step();
    check("R3 dropped store not found", DATA_W'(ld_hit), 64'd0);
    ld_bank = 1; ld_addr = 16'h0100;
    step();
    check("R8 other bank miss", DATA_W'(ld_hit), 64'd0);
    ld_bank = 0; ld_addr = 16'h0105;
    step();
    check("R9 queued store found", DATA_W'(ld_hit), 64'd1);
    quiet();

    // Drain bank 0 on tag-lookup cycles only (R5, R7); bank 1 stays quiet (R8).
    for (int i = 0; i < DEPTH; i++) begin
      bank_tag_busy = 2'b01;
      step();
      check("R8 no write on bank 1", DATA_W'(wr_valid[1]), 64'd0);
    end
    step();
    check("R3 dropped store never written", DATA_W'(wr_valid[0]), 64'd0);
    quiet();

    // Two stores to the same address in bank 1: newest wins (R9).
    st_valid = 1; st_bank = 1; st_addr = 16'h0005; st_data = 64'h1111;
    step();
    st_data = 64'h2222;
    step();
    quiet();
    ld_valid = 1; ld_bank = 1; ld_addr = 16'h0005;
    bank_idle = 2'b10;
    step();
    check("R9 newest match", ld_data, 64'h2222);
    quiet();
    repeat (3) begin bank_idle = 2'b11; step(); end

    // Random traffic with a narrow address range.
    for (int n = 0; n < 4000; n++) begin
      st_valid = ($urandom % 2) == 0;
      st_bank  = BANK_W'($urandom % NB);
      st_addr  = 16'($urandom % 16);
      st_data  = {$urandom, $urandom};
      for (int b = 0; b < NB; b++) begin
        bank_idle[b]     = ($urandom % 10) < 3;
        bank_tag_busy[b] = ($urandom % 10) < 2;
      end
      ld_valid = ($urandom % 2) == 0;
      ld_bank  = BANK_W'($urandom % NB);
      ld_addr  = 16'($urandom % 16);
      step();
    end

    // Reset with entries present empties the queues (R10).
    quiet();
    st_valid = 1; st_addr = 16'h0007;
    step();
    quiet();
    rst = 1;
    @(posedge clk);
    @(negedge clk);
    rst = 0;
    model_clear();
    check("R10 full cleared", DATA_W'(bank_full), '0);
    ld_valid = 1; ld_addr = 16'h0007; bank_idle = '1;
    step();
    check("R10 queue empty", DATA_W'(ld_hit), 64'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule